// File: doc/BRIEF.md
# Trigger Latency Sequencer

This block orders the steps of one acquisition for a silicon strip test bench running on the 40 MHz clock that also samples the front-end analogue pipeline. It has two modes.

In pulsed-excitation mode, a start command first sends an 8-bit fine-delay code, most significant bit first, over a three-wire serial link to an external delay line with 1 ns steps. When the load has completed, the block emits a single-cycle pulse to fire the excitation source. Exactly `LATENCY` clock cycles later it emits the single-cycle readout trigger to the front-end chip, so that the pipeline cell holding the excited sample is the one that gets read out.

In external-source mode, an asynchronous, already-discriminated trigger input is synchronised and edge-detected. The readout trigger then follows the detected edge by the same fixed latency. In both modes, anything that arrives while a sequence is in flight is dropped.

Top module: `trig_latency_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, `trig_out`, `chip_trig`, `busy`, `dl_sclk` and `dl_le` are all low.
- R2: With `src_mode` low, a `start` sampled while `busy` is low loads the `delay_code` value present at that edge onto `dl_sdata`, most significant bit first. The load makes exactly 8 rising edges of `dl_sclk`, and each bit is valid at its rising edge. Changing `delay_code` after acceptance has no effect on the load.
- R3: `dl_sclk` stays high for `SCLK_HALF` cycles on each pulse. After the last falling edge of `dl_sclk`, `dl_le` rises `SCLK_HALF` cycles later and stays high for `SCLK_HALF` cycles. While `dl_le` is high, `dl_sclk` is low.
- R4: `trig_out` is high for exactly one cycle, in the cycle right after the last cycle of `dl_le`. Each accepted start produces one such pulse.
- R5: `chip_trig` is high for exactly one cycle. In pulsed-excitation mode it is high exactly `LATENCY` (128) cycles after the `trig_out` cycle.
- R6: With `src_mode` high, if `ext_trig` is first sampled high at clock edge k while the block is idle, `chip_trig` is high in the cycle that begins at edge k + (`SYNC_STAGES`-1) + `LATENCY` (k+129 by default).
- R7: `busy` goes high in the cycle after a start or an edge is accepted. It stays high through the `chip_trig` cycle and is low in the cycle after it.
- R8: While `busy` is high, further `start` pulses and `ext_trig` edges are dropped, not queued. No extra `trig_out`, `dl_le` or `chip_trig` follows.
- R9: Holding `ext_trig` high yields only one `chip_trig`. A new trigger needs a new rising edge.
- R10: With `src_mode` high, `start` causes no serial activity, no `trig_out` and no `chip_trig`. With `src_mode` low, `ext_trig` causes no `chip_trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock, shared with pipeline sampling |
| rst_n | input | 1 | Synchronous active-low reset |
| src_mode | input | 1 | 0: pulsed excitation generated here, 1: external trigger input |
| start | input | 1 | Start command, acted on only when idle in pulsed-excitation mode |
| delay_code | input | DLY_W (8) | Fine-delay code in 1 ns steps, captured at start |
| ext_trig | input | 1 | Asynchronous discriminated external trigger |
| trig_out | output | 1 | One-cycle pulse that fires the excitation source |
| chip_trig | output | 1 | One-cycle readout trigger to the front-end chip |
| dl_sclk | output | 1 | Serial clock to the delay line |
| dl_sdata | output | 1 | Serial data to the delay line, MSB first |
| dl_le | output | 1 | Latch-enable strobe to the delay line |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions assume that `src_mode` changes only while `busy` is low. They also assume that `start` is a synchronous input, while `ext_trig` may arrive at any time but stays at each level for at least one clock cycle. The bench respects these limits: it changes `src_mode` only between sequences and drives every input half a cycle away from the active edge. Its random delay codes and random gaps between external edges, along with the deliberate starts and edges fired into a busy sequence, therefore exercise only the dropping behaviour and never an undefined mode switch.

// File: rtl/tls_pkg.sv
// Package: shared state encodings for the trigger latency sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package tls_pkg;

    // Top-level sequence phases.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;

    // Serial delay-line loader phases.
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_LATCH = 2'd2
    } ld_state_t;

endpackage

// File: rtl/tls_sync_edge.sv
// Module: tls_sync_edge
// Brings an asynchronous level into the clock domain through STAGES flops,
// then flags its rising edge for one cycle.
// Assumes: STAGES >= 2; input pulses last at least one clock period.
module tls_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // One-cycle flag on a synchronised low-to-high transition.
    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tls_serial_loader.sv
// Module: tls_serial_loader
// Sends a W-bit code MSB first on a divided serial clock. It then waits one
// half-period and strobes latch-enable for one half-period, and finally pulses
// done for one cycle.
// Assumes: go is only raised while the loader is idle; HALF >= 2; W >= 2.
module tls_serial_loader
    import tls_pkg::*;
#(
    parameter int W    = 8,
    parameter int HALF = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] code_in,
    output logic         sclk,
    output logic         sdata,
    output logic         le,
    output logic         done
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);
    localparam logic [BW-1:0] BIT_TOP  = BW'(W - 1);

    ld_state_t     st_q;
    logic [W-1:0]  shreg_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic          sclk_q;
    logic          le_q;
    logic          done_q;

    // Phase machine: shift bits, leave a gap, strobe the latch, report done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= LD_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
            le_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                LD_IDLE: begin
                    if (go) begin
                        shreg_q <= code_in;
                        bit_q   <= BIT_TOP;
                        cnt_q   <= '0;
                        sclk_q  <= 1'b0;
                        st_q    <= LD_SHIFT;
                    end
                end
                LD_SHIFT: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == '0) begin
                                st_q <= LD_LATCH;
                            end else begin
                                bit_q   <= bit_q - 1'b1;
                                shreg_q <= {shreg_q[W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LD_LATCH: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        if (!le_q) begin
                            le_q <= 1'b1;
                        end else begin
                            le_q   <= 1'b0;
                            done_q <= 1'b1;
                            st_q   <= LD_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= LD_IDLE;
            endcase
        end
    end

    // Outputs come straight from flops.
    assign sclk  = sclk_q;
    assign sdata = shreg_q[W-1];
    assign le    = le_q;
    assign done  = done_q;

endmodule

// File: rtl/tls_latency_timer.sv
// Module: tls_latency_timer
// After a one-cycle arm pulse in cycle c, raises fire for one cycle in
// cycle c + LATENCY.
// Assumes: LATENCY >= 2; arm is not raised while the timer is running.
module tls_latency_timer #(
    parameter int LATENCY = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);

    localparam int LW = $clog2(LATENCY + 1);
    localparam logic [LW-1:0] LOAD_VAL = LW'(LATENCY - 1);

    logic [LW-1:0] cnt_q;
    logic          run_q;

    // Down-counter that reaches zero in the firing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (arm) begin
            cnt_q <= LOAD_VAL;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Fire in the single cycle where a running count sits at zero.
    assign fire = run_q & (cnt_q == '0);

endmodule

// File: rtl/trig_latency_seq.sv
// Module: trig_latency_seq (top)
// Orders delay-line load, excitation pulse and readout trigger, or turns an
// external trigger edge into a readout trigger, always with a fixed latency.
// Assumes: src_mode changes only while busy is low; start is synchronous.
module trig_latency_seq
    import tls_pkg::*;
#(
    parameter int LATENCY     = 128,
    parameter int DLY_W       = 8,
    parameter int SCLK_HALF   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_mode,
    input  logic             start,
    input  logic [DLY_W-1:0] delay_code,
    input  logic             ext_trig,
    output logic             trig_out,
    output logic             chip_trig,
    output logic             dl_sclk,
    output logic             dl_sdata,
    output logic             dl_le,
    output logic             busy
);

    seq_state_t state_q;
    logic       ext_rise;
    logic       ld_done;
    logic       accept_start;
    logic       accept_ext;
    logic       fire_pulse;
    logic       lat_arm;
    logic       fire;

    // External trigger enters the clock domain here.
    tls_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (ext_rise)
    );

    // Acceptance is gated by idleness and by mode.
    assign accept_start = (state_q == SEQ_IDLE) & ~src_mode & start;
    assign accept_ext   = (state_q == SEQ_IDLE) &  src_mode & ext_rise;

    // Delay-line loader, started by an accepted start command.
    tls_serial_loader #(.W(DLY_W), .HALF(SCLK_HALF)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (accept_start),
        .code_in (delay_code),
        .sclk    (dl_sclk),
        .sdata   (dl_sdata),
        .le      (dl_le),
        .done    (ld_done)
    );

    // Excitation pulse fires on the loader's done cycle.
    assign fire_pulse = (state_q == SEQ_LOAD) & ld_done;
    assign lat_arm    = fire_pulse | accept_ext;

    // Fixed pipeline latency to the readout trigger.
    tls_latency_timer #(.LATENCY(LATENCY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (lat_arm),
        .fire  (fire)
    );

    // Sequence control: idle, loading the delay line, waiting on latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept_start)    state_q <= SEQ_LOAD;
                    else if (accept_ext) state_q <= SEQ_WAIT;
                end
                SEQ_LOAD: if (fire_pulse) state_q <= SEQ_WAIT;
                SEQ_WAIT: if (fire)       state_q <= SEQ_IDLE;
                default:                  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Outputs.
    assign trig_out  = fire_pulse;
    assign chip_trig = fire;
    assign busy      = (state_q != SEQ_IDLE);

endmodule

// File: rtl/tls_checker.sv
// Module: tls_checker
// Property checks for trig_latency_seq, bound to every instance of it.
// Assumes: same LATENCY as the bound instance.
module tls_checker #(
    parameter int LATENCY = 128
) (
    input logic clk,
    input logic rst_n,
    input logic trig_out,
    input logic chip_trig,
    input logic busy,
    input logic dl_sclk,
    input logic dl_sdata,
    input logic dl_le,
    input logic lat_arm
);

    localparam int KW = $clog2(LATENCY + 1);

    logic [KW-1:0] win_q;

    // Independent window counter: 1 exactly LATENCY cycles after an arm.
    always_ff @(posedge clk) begin
        if (!rst_n)            win_q <= '0;
        else if (lat_arm)      win_q <= KW'(LATENCY);
        else if (win_q != '0)  win_q <= win_q - 1'b1;
    end

    assert_serial_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dl_le |-> !dl_sclk);
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_sclk && $past(dl_sclk)) |-> $stable(dl_sdata));
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chip_trig |=> !chip_trig);
    assert_latency_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chip_trig |-> (win_q == KW'(1)));
    assert_latency_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == KW'(1)) |-> chip_trig);
    assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_trig |-> busy);
    assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(chip_trig));
    assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lat_arm |-> (win_q == '0));

endmodule

bind trig_latency_seq tls_checker #(.LATENCY(LATENCY)) u_tls_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_out  (trig_out),
    .chip_trig (chip_trig),
    .busy      (busy),
    .dl_sclk   (dl_sclk),
    .dl_sdata  (dl_sdata),
    .dl_le     (dl_le),
    .lat_arm   (lat_arm)
);

// File: tb/tb_trig_latency_seq.sv
// Bench for trig_latency_seq: directed corners plus seeded random codes/gaps.
module tb_trig_latency_seq;

    localparam int LAT   = 128;
    localparam int DW    = 8;
    localparam int HALF  = 4;
    localparam int SYNC  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_mode = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] delay_code = '0;
    logic          ext_trig = 1'b0;
    logic          trig_out, chip_trig, dl_sclk, dl_sdata, dl_le, busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Monitor state.
    logic prev_sclk = 0, prev_le = 0, prev_trig = 0, prev_chip = 0;
    int   hi_run = 0, le_run = 0, last_fall = 0, le_last = 0;
    int   nbits = 0, cap_bits = 0, n_trig = 0, n_chip = 0, n_le = 0;
    int   trig_cyc = 0, chip_cyc = 0;
    logic [DW-1:0] word = '0, cap_word = '0;

    trig_latency_seq #(.LATENCY(LAT), .DLY_W(DW), .SCLK_HALF(HALF),
                       .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .src_mode(src_mode), .start(start),
        .delay_code(delay_code), .ext_trig(ext_trig), .trig_out(trig_out),
        .chip_trig(chip_trig), .dl_sclk(dl_sclk), .dl_sdata(dl_sdata),
        .dl_le(dl_le), .busy(busy)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_chip_laser(input int t);
        return t + LAT;
    endfunction

    function automatic int exp_chip_src(input int drive_cyc);
        return drive_cyc + SYNC + LAT;
    endfunction

    // Port monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dl_sclk && !prev_sclk) begin
                word  = {word[DW-2:0], dl_sdata};
                nbits = nbits + 1;
            end
            if (dl_sclk) hi_run++;
            else if (prev_sclk) begin
                check(hi_run == HALF, "R3 sclk high width", hi_run, HALF);
                hi_run = 0;
                last_fall = cyc;
            end
            if (dl_le && !prev_le) begin
                check(cyc - last_fall == HALF, "R3 latch gap", cyc - last_fall, HALF);
                cap_word = word; cap_bits = nbits; word = '0; nbits = 0; n_le++;
            end
            if (dl_le) le_run++;
            else if (prev_le) begin
                check(le_run == HALF, "R3 latch width", le_run, HALF);
                le_run = 0;
                le_last = cyc - 1;
            end
            if (trig_out && prev_trig) check(0, "R4 trig_out width", 2, 1);
            if (trig_out && !prev_trig) begin n_trig++; trig_cyc = cyc; end
            if (chip_trig && prev_chip) check(0, "R5 chip_trig width", 2, 1);
            if (chip_trig && !prev_chip) begin
                n_chip++; chip_cyc = cyc;
                check(busy == 1'b1, "R7 busy during chip_trig", int'(busy), 1);
            end
            if (prev_chip) check(busy == 1'b0, "R7 busy release", int'(busy), 0);
            prev_sclk = dl_sclk; prev_le = dl_le; prev_trig = trig_out; prev_chip = chip_trig;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_chip(input int n0, input string req);
        int t = 0;
        while (n_chip == n0 && t < 3000) begin @(negedge clk); t++; end
        check(n_chip != n0, req, n_chip - n0, 1);
        @(negedge clk);
    endtask

    // Pulsed-excitation sequence, optionally poked while busy.
    task automatic do_laser(input logic [DW-1:0] code, input bit poke);
        int c0 = n_chip, t0 = n_trig, l0 = n_le;
        @(negedge clk);
        src_mode = 1'b0; delay_code = code; start = 1'b1;
        @(negedge clk);
        start = 1'b0; delay_code = ~code;
        check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        if (poke) begin
            idle(30);
            start = 1'b1; @(negedge clk); start = 1'b0;
            idle(60);
            ext_trig = 1'b1; idle(4); ext_trig = 1'b0;
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_chip(c0, "R5 chip_trig seen");
        check(cap_word == code, "R2 serial word", int'(cap_word), int'(code));
        check(cap_bits == DW, "R2 bit count", cap_bits, DW);
        check(trig_cyc == le_last + 1, "R4 trig after latch", trig_cyc, le_last + 1);
        check(chip_cyc == exp_chip_laser(trig_cyc), "R5 latency", chip_cyc, exp_chip_laser(trig_cyc));
        if (poke) begin
            idle(250);
            check(n_chip == c0 + 1, "R8 chip count", n_chip - c0, 1);
            check(n_trig == t0 + 1, "R8 trig count", n_trig - t0, 1);
            check(n_le == l0 + 1, "R8 latch count", n_le - l0, 1);
        end
    endtask

    // External-trigger sequence; hold keeps the level high, poke re-edges while busy.
    task automatic do_src(input int gap, input bit hold, input bit poke);
        int c0 = n_chip, t0 = n_trig, l0 = n_le, dc;
        @(negedge clk); src_mode = 1'b1;
        idle(gap);
        ext_trig = 1'b1; dc = cyc;
        if (!hold) begin idle(2); ext_trig = 1'b0; end
        if (poke) begin idle(40); ext_trig = 1'b0; idle(3); ext_trig = 1'b1; idle(3); ext_trig = 1'b0; end
        wait_chip(c0, "R6 chip_trig seen");
        check(chip_cyc == exp_chip_src(dc), "R6 source latency", chip_cyc, exp_chip_src(dc));
        check(n_trig == t0 && n_le == l0, "R10 no excitation in source mode", n_trig - t0, 0);
        if (hold || poke) begin
            idle(250);
            check(n_chip == c0 + 1, hold ? "R9 held level single trigger" : "R8 edge while busy dropped",
                  n_chip - c0, 1);
        end
        ext_trig = 1'b0; idle(4);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c0, t0, l0;
        void'($urandom(32'd20240607));
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        check({trig_out, chip_trig, busy, dl_sclk, dl_le} == 5'b0, "R1 reset state",
              int'({trig_out, chip_trig, busy, dl_sclk, dl_le}), 0);
        idle(3);

        // Corner codes.
        do_laser(8'h00, 1'b0);
        do_laser(8'hFF, 1'b0);
        do_laser(8'h80, 1'b0);
        do_laser(8'h01, 1'b0);
        // Start and ext edges while busy (R8, R10 ext ignored in laser mode).
        do_laser(8'hA5, 1'b1);
        // Random codes.
        for (int i = 0; i < 10; i++) do_laser(DW'($urandom), 1'b0);

        // Laser mode: lone ext edge ignored (R10).
        c0 = n_chip;
        @(negedge clk); src_mode = 1'b0; ext_trig = 1'b1; idle(3); ext_trig = 1'b0;
        idle(200);
        check(n_chip == c0, "R10 ext_trig ignored in laser mode", n_chip - c0, 0);

        // Source mode: start ignored (R10).
        c0 = n_chip; t0 = n_trig; l0 = n_le;
        @(negedge clk); src_mode = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0;
        idle(300);
        check(n_chip == c0 && n_trig == t0 && n_le == l0, "R10 start ignored in source mode",
              (n_chip - c0) + (n_trig - t0) + (n_le - l0), 0);
        check(busy == 1'b0, "R10 stays idle", int'(busy), 0);

        do_src(3, 1'b0, 1'b0);
        do_src(1, 1'b1, 1'b0);
        do_src(5, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) do_src(1 + int'($urandom % 20), 1'b0, 1'b0);

        // Back to laser after source runs.
        do_laser(DW'($urandom), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule